// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block sits on a two-wire serial bus as a target device in front of a byte-wide memory. A parameter selects one of two array sizes: 4096 or 8192 bytes. The block watches the bus for START and STOP conditions. It accepts a select byte carrying a fixed type code and three strap-matched chip bits. It then takes a two-byte word address and stores or returns data bytes. The block drives SDA only by pulling it low through an output enable. An external pull-up is assumed.

All reads and writes share one address counter. That counter survives from one transaction to the next. A read that skips the address phase therefore picks up at the byte after the last one touched. To read from a chosen location, a host first sends an address-only write and then a repeated START with a read select. Each host ACK during a read fetches the byte at the next address. The counter runs across the whole array and wraps from the top address back to zero. A write-protect input leaves the select and address phases untouched. It refuses the first data byte with a NACK.

Top module: `eeprom_i2c_target`

## Requirements
- R1: The target ACKs a select byte only when bits 7:4 are 4'b1010 and bits 3:1 equal `chip_sel`. Bit 0 is the direction: 0 means write, 1 means read. On a mismatch the target NACKs, ignores every later byte until the next START, and changes nothing.
- R2: In a write, the target ACKs the select byte, the high address byte, the low address byte and each data byte. Each data byte is stored at the counter, and the counter then advances by one.
- R3: A write select with two address bytes, followed by a repeated START and a read select, returns the byte stored at the loaded address.
- R4: A read select with no address phase returns the byte at the last accessed address plus one. After an access to the top address it returns address 0.
- R5: When the host ACKs a data byte, the target sends the byte at the next address. Across the top address the sequence continues at 0.
- R6: After the host NACKs a data byte, the target no longer drives SDA, including while the STOP is sent.
- R7: While `wp` is high, the target ACKs the select byte and both address bytes. It NACKs the first data byte and leaves the location unchanged. The counter stays at the loaded address.
- R8: A STOP, or a START part way through a byte, abandons the transfer. The counter keeps its last value, and a new select byte is accepted straight after a START.
- R9: With the 4096-byte array, bits 7:4 of the high address byte are ignored, so address 16'hF005 selects location 12'h005.
- R10: After reset the target does not drive SDA, and the counter is 0.
- R11: The target changes SDA only while SCL is low. Data bytes are sent MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Resolved bus data level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| chip_sel | input | 3 | Strap value matched against select bits 3:1 |
| wp | input | 1 | Write protect; 1 refuses data bytes |

## Verification
SCL and SDA each pass through two synchronizer flops. An edge register follows. The sequencer updates `sda_oe` on the third clock edge after SCL falls. This applies to ACKs, data bits and releases alike. The bench holds SCL low for six clocks after every falling edge before it raises SCL again, so each response has settled well before it is needed. ACK and data values are sampled once mid-way through the SCL-high phase. Read bits are sampled three times across that phase to confirm SDA stays stable. Stored data and counter effects appear only in a later read, so those checks are made on the bytes that the next read returns.

// File: rtl/eeprom_i2c_pkg.sv
// Shared types and constants for the serial EEPROM target.
// Assumes: no other package defines these names.
package eeprom_i2c_pkg;

    // Which byte of a transaction the sequencer is handling.
    typedef enum logic [2:0] {
        PH_IDLE,   // off the bus until a START
        PH_SEL,    // receiving the select byte
        PH_AHI,    // receiving the high address byte
        PH_ALO,    // receiving the low address byte
        PH_WR,     // receiving data bytes
        PH_RD      // sending data bytes
    } phase_t;

    // Fixed type code expected in select bits 7:4.
    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/eeprom_bus_cond.sv
// Bus conditioner: synchronizes SCL and SDA to clk and flags SCL edges
// plus START and STOP conditions (SDA edges while SCL is high).
// Assumes: SYNC_STAGES >= 2; the bus idles high.
module eeprom_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_hi,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic                   scl_p;
    logic                   sda_p;

    // Synchronizer chains plus one stage of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
            scl_p <= scl_q[SYNC_STAGES-1];
            sda_p <= sda_q[SYNC_STAGES-1];
        end
    end

    // Edge and condition decode from current and previous samples.
    always_comb begin
        scl_hi    = scl_q[SYNC_STAGES-1];
        sda_lvl   = sda_q[SYNC_STAGES-1];
        scl_rise  = scl_hi & ~scl_p;
        scl_fall  = ~scl_hi & scl_p;
        start_det = scl_hi & scl_p & sda_p & ~sda_lvl;
        stop_det  = scl_hi & scl_p & ~sda_p & sda_lvl;
    end

endmodule

// File: rtl/eeprom_byte_ram.sv
// Simple synchronous RAM: one write port, one registered read port.
// Assumes: read-during-write to the same address returns the old byte.
module eeprom_byte_ram #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    // Store on write enable; register the byte at the read address every cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/eeprom_i2c_target.sv
// Serial EEPROM target: byte sequencer, ACK generation and the shared
// address counter in front of an internal RAM.
// Assumes: clk runs at least 8x faster than SCL.
// Assumes: SDA is open-drain with an external pull-up.
module eeprom_i2c_target
    import eeprom_i2c_pkg::*;
#(
    parameter bit LARGE_ARRAY = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [2:0] chip_sel,
    input  logic       wp
);

    localparam int AW = LARGE_ARRAY ? 13 : 12;

    logic          scl_hi, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    phase_t        phase;
    logic          in_ack;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic [7:0]    addr_hi;
    logic [AW-1:0] addr_cnt;
    logic          rd_mode;
    logic          mack;
    logic [7:0]    rdata;
    logic          bus_evt, byte_done, sel_match, wr_commit, load_addr;

    eeprom_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_hi(scl_hi), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    eeprom_byte_ram #(.AW(AW), .DW(8)) u_ram (
        .clk(clk), .we(wr_commit), .waddr(addr_cnt), .wdata(shreg),
        .raddr(addr_cnt), .rdata(rdata)
    );

    // Per-cycle decode of byte boundaries, select match and commits.
    always_comb begin
        bus_evt   = start_det | stop_det;
        byte_done = scl_fall & ~in_ack & (bitcnt == 4'd8) & ~bus_evt;
        sel_match = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == chip_sel);
        wr_commit = byte_done & (phase == PH_WR) & ~wp;
        load_addr = byte_done & (phase == PH_ALO);
    end

    // Byte sequencer: shifts bits, generates ACKs, drives read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            in_ack   <= 1'b0;
            bitcnt   <= 4'd0;
            shreg    <= 8'd0;
            addr_hi  <= 8'd0;
            addr_cnt <= '0;
            rd_mode  <= 1'b0;
            mack     <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            phase  <= PH_SEL;
            in_ack <= 1'b0;
            bitcnt <= 4'd0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            phase  <= PH_IDLE;
            in_ack <= 1'b0;
            bitcnt <= 4'd0;
            sda_oe <= 1'b0;
        end else if (phase == PH_RD) begin
            if (scl_fall && !in_ack) begin
                if (bitcnt == 4'd8) begin
                    sda_oe <= 1'b0;
                    in_ack <= 1'b1;
                end else begin
                    sda_oe <= ~shreg[6];
                    shreg  <= {shreg[6:0], 1'b0};
                    bitcnt <= bitcnt + 4'd1;
                end
            end else if (scl_rise && in_ack) begin
                mack <= ~sda_lvl;
            end else if (scl_fall && in_ack) begin
                in_ack <= 1'b0;
                if (mack) begin
                    shreg    <= rdata;
                    sda_oe   <= ~rdata[7];
                    bitcnt   <= 4'd1;
                    addr_cnt <= addr_cnt + 1'b1;
                end else begin
                    phase  <= PH_IDLE;
                    sda_oe <= 1'b0;
                end
            end
        end else if (phase != PH_IDLE) begin
            if (scl_rise && !in_ack) begin
                shreg  <= {shreg[6:0], sda_lvl};
                bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
                case (phase)
                    PH_SEL: begin
                        if (sel_match) begin
                            in_ack  <= 1'b1;
                            sda_oe  <= 1'b1;
                            rd_mode <= shreg[0];
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_AHI: begin
                        addr_hi <= shreg;
                        in_ack  <= 1'b1;
                        sda_oe  <= 1'b1;
                    end
                    PH_ALO: begin
                        addr_cnt <= AW'({addr_hi, shreg});
                        in_ack   <= 1'b1;
                        sda_oe   <= 1'b1;
                    end
                    PH_WR: begin
                        if (wp) begin
                            phase <= PH_IDLE;
                        end else begin
                            addr_cnt <= addr_cnt + 1'b1;
                            in_ack   <= 1'b1;
                            sda_oe   <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (scl_fall && in_ack) begin
                in_ack <= 1'b0;
                bitcnt <= 4'd0;
                sda_oe <= 1'b0;
                case (phase)
                    PH_SEL: begin
                        if (rd_mode) begin
                            phase    <= PH_RD;
                            shreg    <= rdata;
                            sda_oe   <= ~rdata[7];
                            bitcnt   <= 4'd1;
                            addr_cnt <= addr_cnt + 1'b1;
                        end else begin
                            phase <= PH_AHI;
                        end
                    end
                    PH_AHI:  phase <= PH_ALO;
                    PH_ALO:  phase <= PH_WR;
                    default: ;
                endcase
            end
        end
    end

    // R8: a STOP always leaves the sequencer idle with SDA released.
    a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (phase == PH_IDLE && !sda_oe));

    // R8: a START always re-arms reception of a select byte.
    a_r8_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (phase == PH_SEL && !in_ack && bitcnt == 4'd0));

    // R1: a select byte that does not match is never acknowledged.
    a_r1_mismatch_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_SEL && !sel_match) |=> (!sda_oe && phase == PH_IDLE));

    // R7: write protection refuses the data byte.
    a_r7_wp_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_WR && wp) |=> (!sda_oe && phase == PH_IDLE));

    // R4: apart from an address load, the counter only ever steps by one.
    a_r4_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(addr_cnt) && !$past(load_addr)) |-> (addr_cnt == AW'($past(addr_cnt) + 1'b1)));

    // R11: the target starts pulling SDA low only while SCL is low.
    a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_hi);

endmodule

// File: tb/test_eeprom_i2c_target.sv
module test_eeprom_i2c_target;

    localparam int Q   = 6;
    localparam int MEM = 4096;
    localparam logic [2:0] CS = 3'b101;

    logic clk = 1'b0;
    logic rst_n, scl, m_low, wp;
    logic sda_oe;
    logic sda;
    logic [2:0] chip_sel;

    always #2 clk = ~clk;

    assign sda = !(m_low || sda_oe);

    eeprom_i2c_target i_eeprom_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .sda_oe(sda_oe), .chip_sel(chip_sel), .wp(wp)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    int   unstable = 0;
    int   cnt_m = 0;
    logic [7:0] model [0:MEM-1];
    logic       known [0:MEM-1];

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic i2c_start();
        m_low = 1'b0; wt(Q);
        scl = 1'b1;   wt(Q);
        m_low = 1'b1; wt(Q);
        scl = 1'b0;   wt(1);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; wt(Q);
        scl = 1'b1;   wt(Q);
        m_low = 1'b0; wt(2 * Q);
    endtask

    task automatic bit_out(input logic b);
        m_low = !b; wt(Q);
        scl = 1'b1; wt(2 * Q);
        scl = 1'b0; wt(1);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        m_low = 1'b0; wt(Q);
        scl = 1'b1;   wt(Q);
        ack = !sda;   wt(Q);
        scl = 1'b0;   wt(1);
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] d);
        logic s0, s1, s2;
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wt(Q);
            scl = 1'b1; wt(1); s0 = sda;
            wt(Q - 1);  s1 = sda;
            wt(Q - 1);  s2 = sda;
            wt(1);
            scl = 1'b0;
            d[i] = s1;
            if (s0 !== s1 || s1 !== s2) unstable++;
            wt(1);
        end
        m_low = give_ack; wt(Q);
        scl = 1'b1; wt(2 * Q);
        scl = 1'b0; wt(1);
        m_low = 1'b0;
    endtask

    function automatic logic [7:0] sel(input logic [2:0] c, input logic rw);
        return {4'b1010, c, rw};
    endfunction

    // Expected byte for a read at the model counter; X-safe marker when unknown.
    function automatic logic [31:0] exp_at(input int a);
        return known[a] ? {24'd0, model[a]} : 32'hDEAD;
    endfunction

    // Read body after START: read select, n bytes, NACK on last, STOP.
    task automatic read_body(input string req, input int n);
        logic ack;
        logic [7:0] d;
        wr_byte(sel(CS, 1'b1), ack);
        check(req, {31'd0, ack}, 32'd1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k < n - 1, d);
            if (known[cnt_m]) check(req, {24'd0, d}, exp_at(cnt_m));
            cnt_m = (cnt_m + 1) % MEM;
        end
        wt(2);
        check("R6 released after NACK", {31'd0, sda_oe}, 32'd0);
        m_low = 1'b1; wt(Q);
        scl = 1'b1; wt(Q);
        check("R6 released during STOP", {31'd0, sda_oe}, 32'd0);
        m_low = 1'b0; wt(2 * Q);
    endtask

    task automatic read_cur(input string req, input int n);
        i2c_start();
        read_body(req, n);
    endtask

    task automatic send_addr(input string req, input logic [15:0] a);
        logic ack;
        i2c_start();
        wr_byte(sel(CS, 1'b0), ack); check(req, {31'd0, ack}, 32'd1);
        wr_byte(a[15:8], ack);       check(req, {31'd0, ack}, 32'd1);
        wr_byte(a[7:0], ack);        check(req, {31'd0, ack}, 32'd1);
        cnt_m = int'(a[11:0]);
    endtask

    task automatic read_rand(input string req, input logic [15:0] a, input int n);
        send_addr(req, a);
        i2c_start();
        read_body(req, n);
    endtask

    task automatic do_write(input string req, input logic [15:0] a, input logic [7:0] d);
        logic ack;
        send_addr(req, a);
        wr_byte(d, ack);
        check(req, {31'd0, ack}, 32'd1);
        model[a[11:0]] = d;
        known[a[11:0]] = 1'b1;
        cnt_m = (int'(a[11:0]) + 1) % MEM;
        i2c_stop();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wt(4);
        rst_n = 1'b1; wt(2);
        cnt_m = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic ack;
        logic [15:0] addrs [0:23];
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM; i++) known[i] = 1'b0;
        scl = 1'b1; m_low = 1'b0; wp = 1'b0; chip_sel = CS;
        do_reset();
        check("R10 SDA released after reset", {31'd0, sda_oe}, 32'd0);

        // R2, R3, R4: basic write then random and current-address reads.
        do_write("R2 write acks", 16'h0000, 8'h5A);
        do_write("R2 write acks", 16'h0010, 8'hC3);
        do_write("R2 write acks", 16'h0011, 8'h81);
        do_write("R2 write acks", 16'h0012, 8'h7E);
        read_rand("R3 random read", 16'h0010, 1);
        read_cur("R4 current read follows last", 1);
        read_cur("R4 current read follows last", 1);
        do_write("R2 write acks", 16'h0020, 8'h33);
        do_write("R2 write acks", 16'h0021, 8'hCC);
        cnt_m = 16'h0020;
        send_addr("R2 counter after write", 16'h0020);
        i2c_stop();
        read_cur("R4 counter holds loaded address", 2);

        // R5 sequential read with host ACKs, across the top address.
        do_write("R2 write acks", 16'h0FFE, 8'h11);
        do_write("R2 write acks", 16'h0FFF, 8'h22);
        read_cur("R4 current read wraps to 0", 1);
        read_rand("R5 sequential wraps", 16'h0FFE, 4);

        // R1: wrong chip bits and wrong type code are refused and ignored.
        read_rand("R1 setup", 16'h0010, 1);
        i2c_start();
        wr_byte(sel(CS ^ 3'b001, 1'b0), ack); check("R1 wrong chip bits NACK", {31'd0, ack}, 32'd0);
        wr_byte(8'h00, ack);                  check("R1 ignored until START", {31'd0, ack}, 32'd0);
        wr_byte(8'h00, ack);                  check("R1 ignored until START", {31'd0, ack}, 32'd0);
        i2c_stop();
        i2c_start();
        wr_byte({4'b1011, CS, 1'b0}, ack);    check("R1 wrong type NACK", {31'd0, ack}, 32'd0);
        i2c_stop();
        read_cur("R1 counter untouched by refused select", 1);

        // R7: write protect refuses data but keeps select and address ACKs.
        wp = 1'b1;
        send_addr("R7 select and address ACK under wp", 16'h0010);
        wr_byte(8'hEE, ack);
        check("R7 data NACK under wp", {31'd0, ack}, 32'd0);
        i2c_stop();
        wp = 1'b0;
        read_cur("R7 location unchanged and counter at address", 1);

        // R8: STOP in the middle of the low address byte.
        read_rand("R8 setup", 16'h0020, 1);
        i2c_start();
        wr_byte(sel(CS, 1'b0), ack);
        wr_byte(8'h00, ack);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        i2c_stop();
        read_cur("R8 STOP abort keeps counter", 1);
        // R8: START three bits into a byte, then a read select is accepted.
        i2c_start();
        wr_byte(sel(CS, 1'b0), ack);
        for (int i = 0; i < 3; i++) bit_out(1'b0);
        i2c_start();
        read_body("R8 START abort accepts new select", 1);

        // R9: upper bits of the high address byte are ignored.
        do_write("R9 write with high bits set", 16'hF005, 8'hA7);
        read_rand("R9 upper address bits ignored", 16'h0005, 1);

        // Random writes and reads against the bench model.
        for (int i = 0; i < 24; i++) begin
            addrs[i] = 16'($urandom_range(0, MEM - 1));
            do_write("R2 random write", addrs[i], 8'($urandom));
        end
        for (int i = 0; i < 24; i++) begin
            read_rand("R3 random read back", addrs[i], 1 + int'($urandom_range(0, 2)));
        end

        check("R11 SDA stable while SCL high, MSB first", unstable, 32'd0);

        // R10: counter returns to zero on reset.
        do_reset();
        check("R10 SDA released after reset", {31'd0, sda_oe}, 32'd0);
        read_cur("R10 counter zero after reset", 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule